// File: doc/BRIEF.md
# Programmable Digital Input Glitch Filter

This block conditions 24 raw digital inputs before software reads them. Every input first passes a two-stage synchronizer. A per-channel mask then either sends the input through a debounce stage or lets it through unchanged. All debounced channels share one stability interval. The interval is counted in ticks of 200 ns, which is 10 cycles of the 50 MHz clock. A debounced channel takes a new level only after its synchronized input has differed from its current output for that many ticks.

Software uses a byte-wide register interface with separate write and read addresses. The interval is written as three staged bytes and does not take effect until a reload bit is written to the clear register. The same register also carries a flush bit, which discards every pending count. The conditioned levels are read back as three byte ports.

Top module: `gf_input_filter`

## Requirements
- R1: After reset, every conditioned output, every mask bit, the staged interval and the active interval read as zero.
- R2: A channel whose mask bit is 0 shows its raw level on the read port 3 clock edges after the raw input changes.
- R3: A masked-in channel with active interval N>0 takes its synchronized level at the N-th tick counted while that level differs from the output. A tick occurs in the cycle where the prescaler holds 9.
- R4: While a masked-in channel's synchronized level equals its output, that channel's tick count returns to zero. A bounce back to the old level therefore restarts the wait.
- R5: Writes to the interval bytes change only the staged value. The active interval copies the staged value only on a write to offset 0x07 with bit 0 set.
- R6: An active interval of 0 makes masked-in channels behave exactly like unmasked ones.
- R7: The tick prescaler counts 0 to 9 and wraps. A reload write sets it to 0, so the first tick comes 10 edges after the reload edge.
- R8: A write to offset 0x07 with bit 1 set clears every tick count and loads every output with its current synchronized level.
- R9: Channel c appears at bit c mod 8 of read offset 0x00 + c/8. Its mask bit sits at the same bit of offset 0x0C + c/8, and is read back there.
- R10: The interval bytes sit at offsets 0x08 (bits 7:0), 0x09 (bits 15:8) and 0x0A (bits 19:16). Only the low 4 bits of 0x0A are stored, and its upper read-back bits are 0.
- R11: Writes to the port offsets 0x00 to 0x02 and to unmapped offsets are ignored. Reads of 0x07 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 24 | Unsynchronized input levels |
| wr_en | input | 1 | Register write strobe, one cycle per byte |
| wr_addr | input | 5 | Write byte offset |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 5 | Read byte offset |
| rd_data | output | 8 | Read byte for rd_addr, combinational from registered state |

## Verification
The hardest situation to reach is a debounced channel that keeps bouncing just under the interval. Each excursion must span fewer ticks than N, and the return to the old level must clear the count before the next excursion starts. The stimulus holds the new level for 16 cycles against a 3-tick interval, so at most 2 ticks fall in each window, and it repeats this around short returns. A reload edge pins the prescaler phase, which lets one check catch the exact edge where a 1-tick channel flips. A long phase of sparse random toggles under mixed masks, compared every cycle with a reference model, covers the phases between ticks and toggles.

// File: rtl/gf_pkg.sv
`timescale 1ns/1ps
package gf_pkg;
    typedef logic [4:0] gf_addr_t;
    localparam int OFS_PORT0  = 'h00;
    localparam int OFS_CLEAR  = 'h07;
    localparam int OFS_IVL0   = 'h08;
    localparam int OFS_MASK0  = 'h0C;
    localparam int CLR_RELOAD = 0;
    localparam int CLR_FLUSH  = 1;
endpackage

// File: rtl/gf_tick_gen.sv
`timescale 1ns/1ps
module gf_tick_gen #(
    parameter int TICK_DIV = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] presc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = (st_q.presc == LAST);
        if (restart_i || tick_o) st_d.presc = '0;
        else                     st_d.presc = st_q.presc + PW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    generate
        if (TICK_DIV > 1) begin : g_chk
            // R7: ticks are never back to back
            a_r7_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o);
            // R7: a restart puts the next tick a full period away
            a_r7_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
                restart_i |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/gf_cfg_regs.sv
`timescale 1ns/1ps
module gf_cfg_regs
    import gf_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int IVL_W  = 20
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  gf_addr_t          wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic [NUM_CH-1:0] mask_o,
    output logic [IVL_W-1:0]  stage_o,
    output logic [IVL_W-1:0]  active_o,
    output logic              reload_o,
    output logic              flush_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic [IVL_W-1:0]  stage;
        logic [IVL_W-1:0]  active;
    } st_t;

    st_t st_d, st_q;
    logic clr_hit;

    always_comb begin
        st_d     = st_q;
        clr_hit  = wr_en_i && (wr_addr_i == gf_addr_t'(OFS_CLEAR));
        reload_o = clr_hit && wr_data_i[CLR_RELOAD];
        flush_o  = clr_hit && wr_data_i[CLR_FLUSH];
        if (reload_o) st_d.active = st_q.stage;
        if (wr_en_i) begin
            for (int i = 0; i < IVL_W; i++) begin
                if (wr_addr_i == gf_addr_t'(OFS_IVL0 + i / 8))
                    st_d.stage[i] = wr_data_i[3'(i % 8)];
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_addr_i == gf_addr_t'(OFS_MASK0 + i / 8))
                    st_d.mask[i] = wr_data_i[3'(i % 8)];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mask_o   = st_q.mask;
    assign stage_o  = st_q.stage;
    assign active_o = st_q.active;

    // R5: active interval moves only on a reload write
    a_r5_active_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !reload_o |=> $stable(active_o));
    // R5: staging writes alone never disturb the active value
    a_r5_stage_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !reload_o) |=> (active_o == $past(active_o)));
endmodule

// File: rtl/gf_chan_filter.sv
`timescale 1ns/1ps
module gf_chan_filter #(
    parameter int IVL_W = 20
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             raw_i,
    input  logic             en_i,
    input  logic [IVL_W-1:0] ivl_i,
    input  logic             tick_i,
    input  logic             flush_i,
    output logic             out_o
);
    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             out;
        logic [IVL_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [IVL_W:0] cnt_inc;
    logic           bypass;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        bypass  = !en_i || (ivl_i == '0);
        if (flush_i || bypass) begin
            st_d.out = st_q.s2;
            st_d.cnt = '0;
        end else if (st_q.s2 == st_q.out) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (cnt_inc >= {1'b0, ivl_i}) begin
                st_d.out = st_q.s2;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc[IVL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign out_o = st_q.out;

    // R3: a filtered channel only moves on a tick
    a_r3_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && ivl_i != '0 && !flush_i && !tick_i) |=> $stable(out_o));
    // R4: agreement holds the output and zeroes the count
    a_r4_agree_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && ivl_i != '0 && !flush_i && st_q.s2 == st_q.out) |=> ($stable(out_o) && st_q.cnt == '0));
    // R8: flush discards the pending count
    a_r8_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (st_q.cnt == '0));
endmodule

// File: rtl/gf_input_filter.sv
`timescale 1ns/1ps
module gf_input_filter
    import gf_pkg::*;
#(
    parameter int NUM_CH   = 24,
    parameter int IVL_W    = 20,
    parameter int TICK_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] raw_in,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [4:0]        rd_addr,
    output logic [7:0]        rd_data
);
    logic [NUM_CH-1:0] mask;
    logic [NUM_CH-1:0] filt;
    logic [IVL_W-1:0]  stage_ivl;
    logic [IVL_W-1:0]  active_ivl;
    logic              reload;
    logic              flush;
    logic              tick;

    gf_cfg_regs #(.NUM_CH(NUM_CH), .IVL_W(IVL_W)) u_regs (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .mask_o    (mask),
        .stage_o   (stage_ivl),
        .active_o  (active_ivl),
        .reload_o  (reload),
        .flush_o   (flush)
    );

    gf_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .restart_i (reload),
        .tick_o    (tick)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            gf_chan_filter #(.IVL_W(IVL_W)) u_ch (
                .clk_i   (clk),
                .rst_ni  (rst_n),
                .raw_i   (raw_in[c]),
                .en_i    (mask[c]),
                .ivl_i   (active_ivl),
                .tick_i  (tick),
                .flush_i (flush),
                .out_o   (filt[c])
            );
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == gf_addr_t'(OFS_PORT0 + i / 8)) rd_data[3'(i % 8)] = filt[i];
            if (rd_addr == gf_addr_t'(OFS_MASK0 + i / 8)) rd_data[3'(i % 8)] = mask[i];
        end
        for (int i = 0; i < IVL_W; i++) begin
            if (rd_addr == gf_addr_t'(OFS_IVL0 + i / 8)) rd_data[3'(i % 8)] = stage_ivl[i];
        end
    end

    // R1: outputs sit at zero on the first cycle out of reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (filt == '0));
endmodule

// File: tb/sim_gf_input_filter.sv
`timescale 1ns/1ps
module sim_gf_input_filter;
    localparam int NCH = 24;
    localparam int TD  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] raw = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [7:0]  rd_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit started = 0;
    bit auto_rd = 0;
    bit done = 0;
    string cur_req = "R1";

    gf_input_filter u0 (
        .clk(clk), .rst_n(rst_n), .raw_in(raw), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    // reference model
    logic [23:0] m_s1, m_s2, m_out, m_mask;
    logic [19:0] m_stage, m_active;
    int          m_cnt [NCH];
    int          m_presc;

    always @(posedge clk) begin
        bit tk, rl, fl;
        started = 1;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_out = '0; m_mask = '0;
            m_stage = '0; m_active = '0; m_presc = 0;
            for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
        end else begin
            tk = (m_presc == TD - 1);
            rl = wr_en && wr_addr == 5'h07 && wr_data[0];
            fl = wr_en && wr_addr == 5'h07 && wr_data[1];
            for (int c = 0; c < NCH; c++) begin
                if (fl || !m_mask[c] || m_active == 0) begin
                    m_out[c] = m_s2[c]; m_cnt[c] = 0;
                end else if (m_s2[c] == m_out[c]) begin
                    m_cnt[c] = 0;
                end else if (tk) begin
                    if (m_cnt[c] + 1 >= int'(m_active)) begin
                        m_out[c] = m_s2[c]; m_cnt[c] = 0;
                    end else m_cnt[c] = m_cnt[c] + 1;
                end
            end
            m_s2 = m_s1;
            m_s1 = raw;
            m_presc = (rl || tk) ? 0 : m_presc + 1;
            if (rl) m_active = m_stage;
            if (wr_en) begin
                case (wr_addr)
                    5'h08: m_stage[7:0]   = wr_data;
                    5'h09: m_stage[15:8]  = wr_data;
                    5'h0A: m_stage[19:16] = wr_data[3:0];
                    5'h0C: m_mask[7:0]    = wr_data;
                    5'h0D: m_mask[15:8]   = wr_data;
                    5'h0E: m_mask[23:16]  = wr_data;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] exp_byte(input logic [4:0] a);
        case (a)
            5'h00: return m_out[7:0];
            5'h01: return m_out[15:8];
            5'h02: return m_out[23:16];
            5'h08: return m_stage[7:0];
            5'h09: return m_stage[15:8];
            5'h0A: return {4'h0, m_stage[19:16]};
            5'h0C: return m_mask[7:0];
            5'h0D: return m_mask[15:8];
            5'h0E: return m_mask[23:16];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // per-cycle model compare
    always @(negedge clk) begin
        if (started && !done) chk(cur_req, "model compare", rd_data, exp_byte(rd_addr));
    end

    // background read address rotation over the ports
    always @(posedge clk) begin
        #3;
        if (auto_rd) rd_addr = (rd_addr >= 5'h02) ? 5'h00 : rd_addr + 5'h01;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL R1 watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(posedge clk); #3;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #3;
        wr_en = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        auto_rd = 0;
        @(posedge clk); #3;
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
        auto_rd = 1;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, $sformatf("read 0x%02h", a), v, exp);
    endtask

    task automatic set_raw(input logic [23:0] v);
        @(posedge clk); #3;
        raw = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        logic [7:0] v;
        idle(4);
        #3 rst_n = 1;
        auto_rd = 1;

        cur_req = "R1";
        rd_chk("R1", 5'h00, 8'h00);
        rd_chk("R1", 5'h02, 8'h00);
        rd_chk("R1", 5'h0C, 8'h00);
        rd_chk("R1", 5'h0A, 8'h00);

        cur_req = "R2";
        set_raw(24'hA5C33C);
        idle(5);
        rd_chk("R9", 5'h00, 8'h3C);
        rd_chk("R9", 5'h01, 8'hC3);
        rd_chk("R2", 5'h02, 8'hA5);

        cur_req = "R11";
        wr(5'h00, 8'hFF);
        wr(5'h1F, 8'hFF);
        rd_chk("R11", 5'h00, 8'h3C);
        rd_chk("R11", 5'h07, 8'h00);
        rd_chk("R11", 5'h1F, 8'h00);

        cur_req = "R10";
        wr(5'h08, 8'h34);
        wr(5'h09, 8'h12);
        wr(5'h0A, 8'hFF);
        rd_chk("R10", 5'h08, 8'h34);
        rd_chk("R10", 5'h09, 8'h12);
        rd_chk("R10", 5'h0A, 8'h0F);

        cur_req = "R6";
        wr(5'h0C, 8'hFF); wr(5'h0D, 8'hFF); wr(5'h0E, 8'hFF);
        rd_chk("R9", 5'h0D, 8'hFF);
        set_raw(24'h5A0FF0);
        idle(5);
        rd_chk("R6", 5'h00, 8'hF0);
        rd_chk("R5", 5'h02, 8'h5A);

        cur_req = "R3";
        wr(5'h08, 8'h03); wr(5'h09, 8'h00); wr(5'h0A, 8'h00);
        wr(5'h07, 8'h01);
        set_raw(24'h123456);
        idle(12);
        rd_chk("R3", 5'h00, 8'hF0);
        idle(40);
        rd_chk("R3", 5'h00, 8'h56);
        rd_chk("R3", 5'h02, 8'h12);

        cur_req = "R4";
        set_raw(24'hFFFFFF); idle(15);
        set_raw(24'h123456); idle(4);
        set_raw(24'hFFFFFF); idle(15);
        set_raw(24'h123456); idle(4);
        rd_chk("R4", 5'h00, 8'h56);
        set_raw(24'hFFFFFF); idle(45);
        rd_chk("R4", 5'h00, 8'hFF);

        cur_req = "R7";
        wr(5'h08, 8'h01);
        set_raw(24'h000000); idle(60);
        rd_chk("R7", 5'h00, 8'h00);
        auto_rd = 0;
        @(posedge clk); #3 rd_addr = 5'h00;
        wr(5'h07, 8'h01);
        raw = 24'h0000FF;
        idle(9);
        @(negedge clk);
        chk("R7", "before 10th edge", rd_data, 8'h00);
        @(posedge clk);
        @(negedge clk);
        chk("R7", "at 10th edge", rd_data, 8'hFF);
        auto_rd = 1;

        cur_req = "R8";
        wr(5'h08, 8'd20);
        wr(5'h07, 8'h01);
        set_raw(24'hFFFFFF); idle(8);
        rd_chk("R8", 5'h01, 8'h00);
        wr(5'h07, 8'h02);
        idle(1);
        rd_chk("R8", 5'h01, 8'hFF);
        rd_chk("R8", 5'h02, 8'hFF);

        cur_req = "R5";
        wr(5'h08, 8'h00);
        set_raw(24'h000000); idle(10);
        rd_chk("R5", 5'h00, 8'hFF);
        wr(5'h07, 8'h01);
        idle(4);
        rd_chk("R5", 5'h00, 8'h00);

        cur_req = "R9";
        wr(5'h0C, 8'h0F); wr(5'h0D, 8'h00); wr(5'h0E, 8'hFF);
        wr(5'h08, 8'd20);
        wr(5'h07, 8'h01);
        set_raw(24'hFFFFFF); idle(6);
        rd_chk("R9", 5'h00, 8'hF0);
        rd_chk("R9", 5'h01, 8'hFF);
        rd_chk("R9", 5'h02, 8'h00);

        cur_req = "R4";
        wr(5'h08, 8'h02);
        wr(5'h07, 8'h01);
        wr(5'h0C, 8'h5A); wr(5'h0D, 8'hF0); wr(5'h0E, 8'hFF);
        for (int k = 0; k < 800; k++) begin
            @(posedge clk); #3;
            raw = raw ^ (24'($urandom) & 24'($urandom) & 24'($urandom));
            if (k % 197 == 196) begin
                wr_en = 1; wr_addr = 5'h07; wr_data = 8'h02;
            end else wr_en = 0;
        end
        @(posedge clk); #3 wr_en = 0;
        idle(80);
        rd(5'h0C, v);
        chk("R9", "mask readback", v, 8'h5A);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule